// File: doc/BRIEF.md
# Descriptor XOR/Copy Engine

The engine carries out one work descriptor at a time against a memory port that moves one 32-bit word per access. A descriptor is a control word, a byte length and a set of 48-bit byte addresses. Each address arrives as a 32-bit low half and a 16-bit high half. A one-cycle start strobe delivers the descriptor. The engine takes a copy of every field on that strobe, so the driver can change its inputs at once.

Three operations are carried out. The first is a no-operation, which touches no memory and only raises completion. The second is a copy, which reads from address pair A and writes to address pair B. The third is an XOR, which reads between one and eight source buffers in index order for every word, folds them into one parity word and writes that word to address pair B. Every other operation code ends at once with an error flag, and so do malformed XOR descriptors. A one-cycle done pulse marks the end of each descriptor. An interrupt request goes with it when the descriptor asked for one.

Top module: `xe_engine`

## Requirements
- R1: After reset, busy, mem_rd, mem_wr, done, irq and err are all low.
- R2: The operation code is desc_ctrl[31:28]: 0 is no-operation, 1 is copy and 6 is XOR. Any other code (2 to 5 and 7 to 15) gives done and err together in the cycle after start, with no memory access.
- R3: A no-operation gives done in the cycle after start, with no memory access and err low.
- R4: A copy processes ceil(desc_len/4) words. For word k it reads byte address A+4k and then writes that value to B+4k. The count field is ignored for a copy.
- R5: An XOR takes its source count from desc_ctrl[26:22]. For word k it reads source i at address S_i+4k for i = 0 up to count-1, in that order. It then writes the XOR of the values read to B+4k.
- R6: An XOR ends with done and err in the cycle after start, with no memory access, in three cases: the count is 0, the count is above 8, or the parity-enable bit desc_ctrl[17] is clear. Bit 16 has no effect.
- R7: For each word, the reads are issued in back-to-back cycles. One cycle follows with no access, and the write comes in the cycle after that. mem_rdata must hold the word in the cycle after its read request. mem_rd and mem_wr are never high together.
- R8: done is high for exactly one cycle, the cycle after the final write. irq is high only together with done, and only when desc_ctrl[27] was set. This holds for every outcome, errors included.
- R9: A copy or XOR with desc_len of 0 gives done in the cycle after start, with no memory access and err low.
- R10: busy is high from the cycle after an accepted start up to and including the done cycle. A start while busy is high is ignored, and so is any change to the descriptor inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Descriptor strobe, accepted when idle |
| desc_ctrl | input | 32 | Control word: operation, interrupt, count, parity enable |
| desc_len | input | 32 | Length in bytes |
| pair_a_lo | input | 32 | Address pair A, low half (copy source) |
| pair_a_hi | input | 16 | Address pair A, high half |
| pair_b_lo | input | 32 | Address pair B, low half (destination) |
| pair_b_hi | input | 16 | Address pair B, high half |
| src_lo | input | 256 | XOR source addresses, low halves, source i at [32i+31:32i] |
| src_hi | input | 128 | XOR source addresses, high halves, source i at [16i+15:16i] |
| busy | output | 1 | Descriptor in progress |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 48 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt request, only with done |
| err | output | 1 | Unsupported or malformed descriptor, only with done |

## Verification
The bench goes after XOR with one source and with all eight. A design with an off-by-one in the source loop would skip the last source or read a ninth one. It also covers a length that is not a multiple of four, which a design that truncates instead of rounding up would get short by one write. The rejection cases (count 0, count 9, parity enable clear, each unsupported code) would show up as stray reads in a design that checked too late. A start pulse in the middle of an XOR, with a changed control word, would corrupt the remaining addresses in a design that did not hold its own copy of the descriptor. The bench also runs a copy with a nonzero count field and an XOR with bit 16 set, to show that neither changes the trace.

// File: rtl/xe_pkg.sv
package xe_pkg;

  // Control word field positions (decoded by software-visible layout)
  localparam int XE_OP_LSB   = 28;
  localparam int XE_OP_W     = 4;
  localparam int XE_IRQ_BIT  = 27;
  localparam int XE_CNT_LSB  = 22;
  localparam int XE_CNT_W    = 5;
  localparam int XE_PEN_BIT  = 17;

  localparam logic [XE_OP_W-1:0] XE_OP_NOP  = 4'd0;
  localparam logic [XE_OP_W-1:0] XE_OP_COPY = 4'd1;
  localparam logic [XE_OP_W-1:0] XE_OP_XOR  = 4'd6;

  typedef enum logic [1:0] {K_NOP, K_COPY, K_XOR, K_BAD} xe_kind_t;

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_DRAIN, ST_WRITE, ST_FIN} xe_state_t;

  // Whole words covered by a byte length, rounding up
  function automatic logic [63:0] xe_word_count(logic [63:0] len_b, int unsigned sh);
    logic [63:0] mask;
    mask = (64'd1 << sh) - 64'd1;
    return (len_b >> sh) + {63'd0, |(len_b & mask)};
  endfunction

  // Byte address of word index idx starting at base
  function automatic logic [63:0] xe_word_addr(logic [63:0] base, logic [63:0] idx, int unsigned sh);
    return base + (idx << sh);
  endfunction

endpackage

// File: rtl/xe_decode.sv
module xe_decode
  import xe_pkg::*;
#(
  parameter int MAX_SRC = 8
) (
  input  logic [31:0]                    ctrl,
  output xe_kind_t                       kind,
  output logic [$clog2(MAX_SRC+1)-1:0]   nsrc,
  output logic                           want_irq
);

  localparam int NSRC_W = $clog2(MAX_SRC+1);

  logic [XE_OP_W-1:0]  op;
  logic [XE_CNT_W-1:0] cnt;
  logic                pen;
  logic                cnt_ok;
  logic                unused_ctrl_bits;

  assign op       = ctrl[XE_OP_LSB +: XE_OP_W];
  assign cnt      = ctrl[XE_CNT_LSB +: XE_CNT_W];
  assign pen      = ctrl[XE_PEN_BIT];
  assign want_irq = ctrl[XE_IRQ_BIT];
  assign cnt_ok   = (cnt != '0) && (cnt <= XE_CNT_W'(MAX_SRC));
  // bit 16 (second result enable) and the rest carry no meaning here
  assign unused_ctrl_bits = ^{ctrl[21:18], ctrl[16:0]};

  always_comb begin
    kind = K_BAD;
    nsrc = '0;
    unique case (op)
      XE_OP_NOP:  kind = K_NOP;
      XE_OP_COPY: begin
        kind = K_COPY;
        nsrc = NSRC_W'(1);
      end
      XE_OP_XOR: begin
        if (cnt_ok && pen) begin
          kind = K_XOR;
          nsrc = cnt[NSRC_W-1:0];
        end
      end
      default: kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/xe_accum.sv
module xe_accum #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] acc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (take)  acc <= first ? rdata : (acc ^ rdata);
  end

endmodule

// File: rtl/xe_ctrl.sv
module xe_ctrl
  import xe_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int DATA_W  = 32,
  parameter int MAX_SRC = 8,
  parameter int LEN_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  xe_kind_t                       kind,
  input  logic [$clog2(MAX_SRC+1)-1:0]   nsrc,
  input  logic                           want_irq,
  input  logic [LEN_W-1:0]               len,
  input  logic [ADDR_W-1:0]              base_a,
  input  logic [ADDR_W-1:0]              base_b,
  input  logic [MAX_SRC*ADDR_W-1:0]      srcs,
  output logic                           busy,
  output logic                           mem_rd,
  output logic                           mem_wr,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic                           done,
  output logic                           irq,
  output logic                           err,
  output logic                           rd_take,
  output logic                           rd_first,
  output logic                           accept,
  output logic                           last_wr
);

  localparam int NSRC_W = $clog2(MAX_SRC+1);
  localparam int IDX_W  = $clog2(MAX_SRC);
  localparam int SH     = $clog2(DATA_W/8);

  xe_state_t             state_q;
  logic [ADDR_W-1:0]     src_q [MAX_SRC];
  logic [ADDR_W-1:0]     dst_q;
  logic [NSRC_W-1:0]     nsrc_q;
  logic [LEN_W-1:0]      nwords_q;
  logic [LEN_W-1:0]      widx_q;
  logic [IDX_W-1:0]      sidx_q;
  logic                  irq_q, err_q, take_q, first_q;

  logic [63:0]           words64, addr64;
  logic [ADDR_W-1:0]     sel_base;
  logic                  last_src, last_word, has_work;
  logic                  unused_wide_bits;

  assign words64   = xe_word_count(64'(len), SH);
  assign has_work  = (kind == K_COPY || kind == K_XOR) && (words64 != 64'd0);
  assign accept    = start && (state_q == ST_IDLE);
  assign last_src  = (NSRC_W'(sidx_q) == nsrc_q - NSRC_W'(1));
  assign last_word = (widx_q == nwords_q - LEN_W'(1));
  assign sel_base  = (state_q == ST_WRITE) ? dst_q : src_q[sidx_q];
  assign addr64    = xe_word_addr(64'(sel_base), 64'(widx_q), SH);
  assign unused_wide_bits = ^{addr64[63:ADDR_W], words64[63:LEN_W]};

  assign busy     = (state_q != ST_IDLE);
  assign mem_rd   = (state_q == ST_READ);
  assign mem_wr   = (state_q == ST_WRITE);
  assign mem_addr = (mem_rd || mem_wr) ? addr64[ADDR_W-1:0] : '0;
  assign done     = (state_q == ST_FIN);
  assign irq      = done && irq_q;
  assign err      = done && err_q;
  assign rd_take  = take_q;
  assign rd_first = first_q;
  assign last_wr  = mem_wr && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dst_q    <= '0;
      nsrc_q   <= '0;
      nwords_q <= '0;
      widx_q   <= '0;
      sidx_q   <= '0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
      take_q   <= 1'b0;
      first_q  <= 1'b0;
      for (int i = 0; i < MAX_SRC; i++) src_q[i] <= '0;
    end else begin
      take_q  <= (state_q == ST_READ);
      first_q <= (state_q == ST_READ) && (sidx_q == '0);
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            dst_q    <= base_b;
            nsrc_q   <= nsrc;
            nwords_q <= words64[LEN_W-1:0];
            widx_q   <= '0;
            sidx_q   <= '0;
            irq_q    <= want_irq;
            err_q    <= (kind == K_BAD);
            for (int i = 0; i < MAX_SRC; i++)
              src_q[i] <= (kind == K_COPY && i == 0) ? base_a : srcs[i*ADDR_W +: ADDR_W];
            state_q  <= has_work ? ST_READ : ST_FIN;
          end
        end
        ST_READ: begin
          if (last_src) begin
            sidx_q  <= '0;
            state_q <= ST_DRAIN;
          end else begin
            sidx_q  <= sidx_q + IDX_W'(1);
          end
        end
        ST_DRAIN: state_q <= ST_WRITE;
        ST_WRITE: begin
          if (last_word) begin
            state_q <= ST_FIN;
          end else begin
            widx_q  <= widx_q + LEN_W'(1);
            state_q <= ST_READ;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xe_engine.sv
module xe_engine
  import xe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MAX_SRC = 8,
  parameter int LEN_W   = 32,
  parameter int LO_W    = 32,
  parameter int HI_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [31:0]               desc_ctrl,
  input  logic [LEN_W-1:0]          desc_len,
  input  logic [LO_W-1:0]           pair_a_lo,
  input  logic [HI_W-1:0]           pair_a_hi,
  input  logic [LO_W-1:0]           pair_b_lo,
  input  logic [HI_W-1:0]           pair_b_hi,
  input  logic [MAX_SRC*LO_W-1:0]   src_lo,
  input  logic [MAX_SRC*HI_W-1:0]   src_hi,
  output logic                      busy,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [LO_W+HI_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      done,
  output logic                      irq,
  output logic                      err
);

  localparam int ADDR_W = LO_W + HI_W;
  localparam int NSRC_W = $clog2(MAX_SRC+1);

  // Named internal events, observed by the bound checker
  xe_kind_t                kind_w;
  logic [NSRC_W-1:0]       nsrc_w;
  logic                    want_irq_w;
  logic                    accept_w;
  logic                    last_wr_w;
  logic                    take_w, first_w;
  logic [MAX_SRC*ADDR_W-1:0] src_flat;

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_src
    assign src_flat[g*ADDR_W +: ADDR_W] = {src_hi[g*HI_W +: HI_W], src_lo[g*LO_W +: LO_W]};
  end

  xe_decode #(.MAX_SRC(MAX_SRC)) u_dec (
    .ctrl     (desc_ctrl),
    .kind     (kind_w),
    .nsrc     (nsrc_w),
    .want_irq (want_irq_w)
  );

  xe_ctrl #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .MAX_SRC (MAX_SRC), .LEN_W (LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind     (kind_w),
    .nsrc     (nsrc_w),
    .want_irq (want_irq_w),
    .len      (desc_len),
    .base_a   ({pair_a_hi, pair_a_lo}),
    .base_b   ({pair_b_hi, pair_b_lo}),
    .srcs     (src_flat),
    .busy     (busy),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .done     (done),
    .irq      (irq),
    .err      (err),
    .rd_take  (take_w),
    .rd_first (first_w),
    .accept   (accept_w),
    .last_wr  (last_wr_w)
  );

  xe_accum #(.DATA_W(DATA_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take_w),
    .first (first_w),
    .rdata (mem_rdata),
    .acc   (mem_wdata)
  );

endmodule

// File: rtl/xe_engine_chk.sv
module xe_engine_chk
  import xe_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     start_ok,
  input xe_kind_t kind,
  input logic     last_wr,
  input logic     mem_rd,
  input logic     mem_wr,
  input logic     busy,
  input logic     done,
  input logic     irq,
  input logic     err
);

  p_rw_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_wr_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (!$past(mem_rd) && $past(mem_rd, 2)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_irq_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  p_last_wr_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> (done && !err));

  p_err_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_bad_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && kind == K_BAD) |=> (done && err && !mem_rd && !mem_wr));

  p_nop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && kind == K_NOP) |=> (done && !err && !mem_rd && !mem_wr));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);

endmodule

bind xe_engine xe_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_ok (accept_w),
  .kind     (kind_w),
  .last_wr  (last_wr_w),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .busy     (busy),
  .done     (done),
  .irq      (irq),
  .err      (err)
);

// File: tb/xe_engine_test.sv
`timescale 1ns/1ps
module xe_engine_test;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   desc_ctrl = '0;
  logic [31:0]   desc_len = '0;
  logic [31:0]   pair_a_lo = '0, pair_b_lo = '0;
  logic [15:0]   pair_a_hi = '0, pair_b_hi = '0;
  logic [255:0]  src_lo = '0;
  logic [127:0]  src_hi = '0;
  logic          busy, mem_rd, mem_wr, done, irq, err;
  logic [47:0]   mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  xe_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_ctrl(desc_ctrl), .desc_len(desc_len),
    .pair_a_lo(pair_a_lo), .pair_a_hi(pair_a_hi), .pair_b_lo(pair_b_lo), .pair_b_hi(pair_b_hi),
    .src_lo(src_lo), .src_hi(src_hi), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .irq(irq), .err(err)
  );

  // Behavioural memory: one word per byte address key, read data one cycle later
  logic [31:0] mem [logic [47:0]];

  function automatic logic [31:0] mem_get(logic [47:0] a);
    if (mem.exists(a)) return mem[a];
    return a[31:0] ^ 32'h5A5A_0F0F ^ {a[47:32], 16'h0000};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_get(mem_addr);
    if (mem_wr) mem[mem_addr] = mem_wdata;
  end

  // Expected per-cycle event: 0 quiet, 1 read, 2 write, 3 done
  typedef struct {
    int          kind;
    logic [47:0] addr;
    logic [31:0] data;
    bit          irq;
    bit          err;
  } ev_t;

  ev_t expq[$];
  logic [47:0] pa, pb;
  logic [47:0] bsrc [8];

  function automatic logic [85:0] observe();
    logic [47:0] a;
    logic [31:0] d;
    a = (mem_rd || mem_wr) ? mem_addr : 48'h0;
    d = mem_wr ? mem_wdata : 32'h0;
    return {busy, mem_rd, mem_wr, done, irq, err, a, d};
  endfunction

  function automatic logic [85:0] expect_vec(ev_t e);
    case (e.kind)
      1: return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, e.addr, 32'h0};
      2: return {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, e.addr, e.data};
      3: return {1'b1, 1'b0, 1'b0, 1'b1, e.irq, e.err, 48'h0, 32'h0};
      default: return {1'b1, 5'b0, 48'h0, 32'h0};
    endcase
  endfunction

  task automatic check(string tag, logic [85:0] act, logic [85:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic run_desc(string tag, logic [31:0] c, logic [31:0] l, bit poke);
    int op, cnt, nsrc, nw;
    bit irqb, pen, bad, work;
    logic [47:0] srcs [8];
    ev_t e;
    op   = int'(c[31:28]);
    cnt  = int'(c[26:22]);
    irqb = c[27];
    pen  = c[17];
    bad  = 1'b0;
    work = 1'b0;
    nsrc = 0;
    if (op == 1) begin
      work = 1'b1; nsrc = 1; srcs[0] = pa;
    end else if (op == 6) begin
      if (cnt >= 1 && cnt <= 8 && pen) begin
        work = 1'b1; nsrc = cnt;
        for (int s = 0; s < 8; s++) srcs[s] = bsrc[s];
      end else bad = 1'b1;
    end else if (op != 0) bad = 1'b1;
    nw = int'((longint'(l) + 3) / 4);
    expq.delete();
    if (work) begin
      for (int w = 0; w < nw; w++) begin
        logic [31:0] x;
        x = 32'h0;
        for (int s = 0; s < nsrc; s++) begin
          e = '{kind: 1, addr: srcs[s] + 48'(4*w), data: 32'h0, irq: 1'b0, err: 1'b0};
          expq.push_back(e);
          x ^= mem_get(srcs[s] + 48'(4*w));
        end
        e = '{kind: 0, addr: 48'h0, data: 32'h0, irq: 1'b0, err: 1'b0};
        expq.push_back(e);
        e = '{kind: 2, addr: pb + 48'(4*w), data: x, irq: 1'b0, err: 1'b0};
        expq.push_back(e);
      end
    end
    e = '{kind: 3, addr: 48'h0, data: 32'h0, irq: irqb, err: bad};
    expq.push_back(e);

    @(negedge clk);
    desc_ctrl = c;
    desc_len  = l;
    {pair_a_hi, pair_a_lo} = pa;
    {pair_b_hi, pair_b_lo} = pb;
    for (int s = 0; s < 8; s++) begin
      src_lo[s*32 +: 32] = bsrc[s][31:0];
      src_hi[s*16 +: 16] = bsrc[s][47:32];
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < expq.size(); i++) begin
      check($sformatf("%s cycle %0d", tag, i), observe(), expect_vec(expq[i]));
      if (poke && i == 1) begin
        start = 1'b1;
        desc_ctrl = 32'h2800_0000;
        {pair_b_hi, pair_b_lo} = 48'h0;
      end else if (poke && i == 2) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    check($sformatf("%s idle after (R10)", tag), observe(), 86'h0);
  endtask

  initial begin
    pa = 48'h0012_3400_0100;
    pb = 48'h00AB_CD00_8000;
    for (int s = 0; s < 8; s++)
      bsrc[s] = {16'h0100 + 16'(s), 32'h0000_2000 + 32'(s) * 32'h100};

    repeat (3) @(negedge clk);
    check("R1 reset state", observe(), 86'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", observe(), 86'h0);

    run_desc("R3 nop with irq R8",           32'h0800_0000, 32'd16, 1'b0);
    run_desc("R3 nop without irq",           32'h0000_0000, 32'd0,  1'b0);
    run_desc("R4 copy 2 words irq R8",       32'h0800_0000 | 32'h1000_0000, 32'd8, 1'b0);
    run_desc("R4 copy 5 bytes, count ignored", 32'h17C0_0000, 32'd5, 1'b0);
    run_desc("R5 R7 xor 3 sources irq",      32'h68C2_0000, 32'd12, 1'b0);
    run_desc("R5 R6 xor 8 sources bit16 set", 32'h6203_0000, 32'd4,  1'b0);
    run_desc("R5 xor 1 source 6 bytes",      32'h6042_0000, 32'd6,  1'b0);
    run_desc("R6 xor count 0",               32'h6002_0000, 32'd8,  1'b0);
    run_desc("R6 xor count 9",               32'h6242_0000, 32'd8,  1'b0);
    run_desc("R6 xor parity off irq R8",     32'h6880_0000, 32'd8,  1'b0);
    run_desc("R2 code 2",                    32'h2000_0000, 32'd8,  1'b0);
    run_desc("R2 code 5",                    32'h5000_0000, 32'd8,  1'b0);
    run_desc("R2 code 7",                    32'h7042_0000, 32'd8,  1'b0);
    run_desc("R2 code 8 irq",                32'h8800_0000, 32'd8,  1'b0);
    run_desc("R2 code 15",                   32'hF000_0000, 32'd8,  1'b0);
    run_desc("R9 copy length 0",             32'h1000_0000, 32'd0,  1'b0);
    run_desc("R9 xor length 0",              32'h6082_0000, 32'd0,  1'b0);
    run_desc("R10 start while busy ignored", 32'h6082_0000, 32'd8,  1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule